// File: doc/BRIEF.md
# Byte Load/Store Address Generator

This block produces the memory address and store data for the byte load and store operations of a small 8-bit processor. A decoder outside the block presents a 5-bit operation code together with the current BC, DE and HL register pairs and the accumulator, then pulses a start strobe. The block takes a snapshot of those operands in the cycle the start is accepted. It then steps through a short sequence of its own. The sequence can fetch operand bytes from the instruction stream, perform one data access, and, for the read-modify-write forms, perform a second access. Each step is one request that a shared ready input must acknowledge.

The block supports several addressing forms:
- Register-indirect through BC, DE or HL.
- HL with a post-increment or post-decrement of the pair.
- A high I/O page whose base is fixed, addressed either by C (the low byte of BC) or by one fetched byte.
- A 16-bit direct address assembled from two fetched bytes.
- Storing a fetched byte at HL.
- Incrementing or decrementing the byte at HL in place.

Loaded bytes leave on a write-back port. The updated HL value leaves on a separate port. The decoder chooses where either one goes.

Top module: `lsag_unit`

## Requirements
- R1: Op codes 0-15 use bit 3 to select store (1) or load (0) and bits 2:0 to select the address form: 0 BC, 1 DE, 2 HL, 3 HL then increment, 4 HL then decrement, 5 I/O page with C, 6 I/O page with fetched byte, 7 direct. For forms 0-2 the single access uses the full pair as its address. A load returns the read byte on the write-back port (wb_we_o high with wb_data_o equal to mem_rdata_i in the acknowledged cycle). A store writes the accumulator.
- R2: Forms 3 and 4 access the HL value captured at start. In the cycle the access is acknowledged they present HL+1 or HL-1 on hl_data_o with hl_we_o high. The result wraps modulo 2^16, so 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R3: Forms 5 and 6 address {0xFF, byte}. The byte is C for form 5. For form 6 it is the one instruction-stream byte fetched before the access.
- R4: Form 7 fetches two bytes, low byte first, then accesses {high, low}.
- R5: Op code 16 fetches one byte and then stores it at HL. That is two steps.
- R6: Op codes 17 and 18 read the byte at HL and then write back that byte plus one (17) or minus one (18) to the same address. The byte wraps modulo 256. Neither op uses the write-back port.
- R7: fetch_req_o and mem_req_o are never high in the same cycle.
- R8: While mem_ready_i is low, the current request, its address, its write enable and its store data stay unchanged, and the sequence does not advance.
- R9: A start while busy_o is high is ignored. busy_o stays high from the cycle after acceptance through the final acknowledged step.
- R10: After reset, and whenever idle, busy_o, fetch_req_o, mem_req_o, done_o, hl_we_o and wb_we_o are low.
- R11: done_o pulses in the cycle the final step is acknowledged. The ports that supply register values may change after acceptance without affecting the operation in flight.
- R12: A start with an op code from 19 to 31 is not accepted and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start the operation on op_i when idle |
| op_i | input | 5 | Operation code (see R1, R5, R6, R12) |
| bc_i | input | 16 | BC register pair; the low byte is C |
| de_i | input | 16 | DE register pair |
| hl_i | input | 16 | HL register pair |
| acc_i | input | 8 | Accumulator, the store data for loads/stores of A |
| fetch_data_i | input | 8 | Instruction-stream byte, valid when acknowledged |
| mem_rdata_i | input | 8 | Memory read data, valid when acknowledged |
| mem_ready_i | input | 1 | Acknowledges the current fetch or memory request |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | Final step acknowledged this cycle |
| fetch_req_o | output | 1 | Request for the next instruction-stream byte |
| mem_req_o | output | 1 | Data memory request |
| mem_we_o | output | 1 | Data request is a write |
| mem_addr_o | output | 16 | Data memory address |
| mem_wdata_o | output | 8 | Data memory store byte |
| hl_we_o | output | 1 | Write hl_data_o back to HL |
| hl_data_o | output | 16 | Stepped HL value |
| wb_we_o | output | 1 | Write wb_data_o to the destination register |
| wb_data_o | output | 8 | Loaded byte |

## Verification
The assertions assume that mem_ready_i is the only acknowledge, for fetches and data accesses alike. They also assume that fetch_data_i and mem_rdata_i carry meaning only in a cycle where a matching request is high and is acknowledged. The bench keeps within those assumptions by driving the fetched byte and the read byte from the head of its expected-step queue in the same half cycle it drives mem_ready_i. Garbage appears on those inputs in every other cycle. Register inputs and start are scrambled while an operation is in flight, so the operand snapshot and the busy lockout are exercised without breaking any input assumption.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  localparam int OP_W = 5;

  // Op codes beyond the plain load/store space
  localparam logic [OP_W-1:0] OP_STORE_IMM_HL = 5'd16;
  localparam logic [OP_W-1:0] OP_INC_AT_HL    = 5'd17;
  localparam logic [OP_W-1:0] OP_DEC_AT_HL    = 5'd18;

  // Address form carried in op bits 2:0 (ordering is decoded)
  typedef enum logic [2:0] {
    AM_PAIR_BC   = 3'd0,
    AM_PAIR_DE   = 3'd1,
    AM_PAIR_HL   = 3'd2,
    AM_HL_POSTUP = 3'd3,
    AM_HL_POSTDN = 3'd4,
    AM_PAGE_C    = 3'd5,
    AM_PAGE_IMM  = 3'd6,
    AM_DIRECT    = 3'd7
  } addr_form_e;

  // How the instruction-stream byte(s) are consumed
  typedef enum logic [1:0] {
    FU_NONE   = 2'd0,
    FU_PAGE   = 2'd1,
    FU_DATA   = 2'd2,
    FU_DIRECT = 2'd3
  } fetch_use_e;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_FETCH_LO = 3'd1,
    SQ_FETCH_HI = 3'd2,
    SQ_ACCESS   = 3'd3,
    SQ_RMW_WR   = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic       store;
    logic       load_wb;
    logic       rmw;
    logic       rmw_dec;
    logic       hl_inc;
    logic       hl_dec;
    fetch_use_e fetch_use;
  } op_ctl_t;

endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] IO_PAGE = '1
) (
  input  logic [OP_W-1:0]     op_i,
  input  logic [2*DATA_W-1:0] bc_i,
  input  logic [2*DATA_W-1:0] de_i,
  input  logic [2*DATA_W-1:0] hl_i,
  input  logic [DATA_W-1:0]   acc_i,
  output logic                valid_o,
  output op_ctl_t             ctl_o,
  output logic [2*DATA_W-1:0] base_addr_o,
  output logic [DATA_W-1:0]   base_data_o
);

  localparam int ADDR_W = 2 * DATA_W;

  addr_form_e form;

  always_comb begin
    form        = addr_form_e'(op_i[2:0]);
    valid_o     = 1'b1;
    ctl_o       = '0;
    base_addr_o = hl_i;
    base_data_o = acc_i;
    if (!op_i[OP_W-1]) begin
      ctl_o.store   = op_i[3];
      ctl_o.load_wb = !op_i[3];
      case (form)
        AM_PAIR_BC:   base_addr_o = bc_i;
        AM_PAIR_DE:   base_addr_o = de_i;
        AM_PAIR_HL:   base_addr_o = hl_i;
        AM_HL_POSTUP: ctl_o.hl_inc = 1'b1;
        AM_HL_POSTDN: ctl_o.hl_dec = 1'b1;
        AM_PAGE_C:    base_addr_o = {IO_PAGE, bc_i[DATA_W-1:0]};
        AM_PAGE_IMM: begin
          base_addr_o     = {IO_PAGE, {DATA_W{1'b0}}};
          ctl_o.fetch_use = FU_PAGE;
        end
        AM_DIRECT: begin
          base_addr_o     = {ADDR_W{1'b0}};
          ctl_o.fetch_use = FU_DIRECT;
        end
        default: valid_o = 1'b0;
      endcase
    end else begin
      case (op_i)
        OP_STORE_IMM_HL: begin
          ctl_o.store     = 1'b1;
          ctl_o.fetch_use = FU_DATA;
        end
        OP_INC_AT_HL: ctl_o.rmw = 1'b1;
        OP_DEC_AT_HL: begin
          ctl_o.rmw     = 1'b1;
          ctl_o.rmw_dec = 1'b1;
        end
        default: valid_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lsag_seq.sv
module lsag_seq
  import lsag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       valid_i,
  input  op_ctl_t    ctl_i,
  input  logic       ready_i,
  output logic       busy_o,
  output logic       fetch_req_o,
  output logic       mem_req_o,
  output logic       mem_we_o,
  output logic       accept_o,
  output logic       lo_ok_o,
  output logic       hi_ok_o,
  output logic       rmw_ok_o,
  output logic       fin_o,
  output logic       wb_o,
  output logic       hl_inc_o,
  output logic       hl_dec_o,
  output logic       rmw_dec_o,
  output fetch_use_e fetch_use_o
);

  seq_state_e st_q, st_d;
  op_ctl_t    ctl_q, ctl_d;
  logic       ctl_en;

  // next-state process
  always_comb begin
    accept_o = (st_q == SQ_IDLE) && start_i && valid_i;
    st_d     = st_q;
    case (st_q)
      SQ_IDLE:
        if (accept_o) st_d = (ctl_i.fetch_use == FU_NONE) ? SQ_ACCESS : SQ_FETCH_LO;
      SQ_FETCH_LO:
        if (ready_i) st_d = (ctl_q.fetch_use == FU_DIRECT) ? SQ_FETCH_HI : SQ_ACCESS;
      SQ_FETCH_HI:
        if (ready_i) st_d = SQ_ACCESS;
      SQ_ACCESS:
        if (ready_i) st_d = ctl_q.rmw ? SQ_RMW_WR : SQ_IDLE;
      SQ_RMW_WR:
        if (ready_i) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
    ctl_en = accept_o;
    ctl_d  = ctl_i;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ctl_q <= '0;
    end else begin
      st_q <= st_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  always_comb begin
    busy_o      = (st_q != SQ_IDLE);
    fetch_req_o = (st_q == SQ_FETCH_LO) || (st_q == SQ_FETCH_HI);
    mem_req_o   = (st_q == SQ_ACCESS) || (st_q == SQ_RMW_WR);
    mem_we_o    = ((st_q == SQ_ACCESS) && ctl_q.store) || (st_q == SQ_RMW_WR);
    lo_ok_o     = ready_i && (st_q == SQ_FETCH_LO);
    hi_ok_o     = ready_i && (st_q == SQ_FETCH_HI);
    rmw_ok_o    = ready_i && (st_q == SQ_ACCESS) && ctl_q.rmw;
    wb_o        = ready_i && (st_q == SQ_ACCESS) && ctl_q.load_wb;
    fin_o       = ready_i && (((st_q == SQ_ACCESS) && !ctl_q.rmw) || (st_q == SQ_RMW_WR));
    hl_inc_o    = ctl_q.hl_inc;
    hl_dec_o    = ctl_q.hl_dec;
    rmw_dec_o   = ctl_q.rmw_dec;
    fetch_use_o = ctl_q.fetch_use;
  end

  // R7: a fetch and a data access never share a cycle
  p_single_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req_o && mem_req_o));

  // R8: an unacknowledged fetch is still pending next cycle
  p_fetch_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o && !ready_i |=> fetch_req_o);

  // R11: completion returns the sequencer to idle
  p_done_then_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !busy_o);

  // R9: a start while busy does not restart the sequence
  p_busy_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !fin_o |=> busy_o);

endmodule

// File: rtl/lsag_dp.sv
module lsag_dp
  import lsag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept_i,
  input  logic                lo_ok_i,
  input  logic                hi_ok_i,
  input  logic                rmw_ok_i,
  input  fetch_use_e          fetch_use_i,
  input  logic                rmw_dec_i,
  input  logic                hl_inc_i,
  input  logic [2*DATA_W-1:0] base_addr_i,
  input  logic [DATA_W-1:0]   base_data_i,
  input  logic [2*DATA_W-1:0] hl_i,
  input  logic [DATA_W-1:0]   fetch_data_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [2*DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [2*DATA_W-1:0] hl_next_o
);

  localparam int                ADDR_W   = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] HL_ONE   = ADDR_W'(1);
  localparam logic [DATA_W-1:0] BYTE_ONE = DATA_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d, hl_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_en, data_en;

  // next-value process
  always_comb begin
    addr_d  = addr_q;
    data_d  = data_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    if (accept_i) begin
      addr_d  = base_addr_i;
      data_d  = base_data_i;
      addr_en = 1'b1;
      data_en = 1'b1;
    end else if (lo_ok_i) begin
      if (fetch_use_i == FU_DATA) begin
        data_d  = fetch_data_i;
        data_en = 1'b1;
      end else begin
        addr_d[DATA_W-1:0] = fetch_data_i;
        addr_en            = 1'b1;
      end
    end else if (hi_ok_i) begin
      addr_d[ADDR_W-1:DATA_W] = fetch_data_i;
      addr_en                 = 1'b1;
    end else if (rmw_ok_i) begin
      data_d  = rmw_dec_i ? (rdata_i - BYTE_ONE) : (rdata_i + BYTE_ONE);
      data_en = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      hl_q   <= '0;
    end else begin
      if (addr_en)  addr_q <= addr_d;
      if (data_en)  data_q <= data_d;
      if (accept_i) hl_q   <= hl_i;
    end
  end

  assign addr_o    = addr_q;
  assign wdata_o   = data_q;
  assign hl_next_o = hl_inc_i ? (hl_q + HL_ONE) : (hl_q - HL_ONE);

endmodule

// File: rtl/lsag_unit.sv
module lsag_unit
  import lsag_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] IO_PAGE = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [2*DATA_W-1:0] bc_i,
  input  logic [2*DATA_W-1:0] de_i,
  input  logic [2*DATA_W-1:0] hl_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   fetch_data_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ready_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fetch_req_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [2*DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                hl_we_o,
  output logic [2*DATA_W-1:0] hl_data_o,
  output logic                wb_we_o,
  output logic [DATA_W-1:0]   wb_data_o
);

  localparam int ADDR_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              dec_valid;
  op_ctl_t           dec_ctl;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;

  lsag_decode #(.DATA_W(DATA_W), .IO_PAGE(IO_PAGE)) u_decode (
    .op_i        (op_i),
    .bc_i        (bc_i),
    .de_i        (de_i),
    .hl_i        (hl_i),
    .acc_i       (acc_i),
    .valid_o     (dec_valid),
    .ctl_o       (dec_ctl),
    .base_addr_o (dec_addr),
    .base_data_o (dec_data)
  );

  logic       accept, lo_ok, hi_ok, rmw_ok, fin, wb, hl_inc, hl_dec, rmw_dec;
  fetch_use_e fetch_use;

  lsag_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .valid_i     (dec_valid),
    .ctl_i       (dec_ctl),
    .ready_i     (mem_ready_i),
    .busy_o      (busy_o),
    .fetch_req_o (fetch_req_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .accept_o    (accept),
    .lo_ok_o     (lo_ok),
    .hi_ok_o     (hi_ok),
    .rmw_ok_o    (rmw_ok),
    .fin_o       (fin),
    .wb_o        (wb),
    .hl_inc_o    (hl_inc),
    .hl_dec_o    (hl_dec),
    .rmw_dec_o   (rmw_dec),
    .fetch_use_o (fetch_use)
  );

  lsag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .accept_i     (accept),
    .lo_ok_i      (lo_ok),
    .hi_ok_i      (hi_ok),
    .rmw_ok_i     (rmw_ok),
    .fetch_use_i  (fetch_use),
    .rmw_dec_i    (rmw_dec),
    .hl_inc_i     (hl_inc),
    .base_addr_i  (dec_addr),
    .base_data_i  (dec_data),
    .hl_i         (hl_i),
    .fetch_data_i (fetch_data_i),
    .rdata_i      (mem_rdata_i),
    .addr_o       (mem_addr_o),
    .wdata_o      (mem_wdata_o),
    .hl_next_o    (hl_data_o)
  );

  assign done_o    = fin;
  assign hl_we_o   = fin && (hl_inc || hl_dec);
  assign wb_we_o   = wb;
  assign wb_data_o = mem_rdata_i;

  // R8: a stalled data request keeps address, direction and data
  p_access_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R3: page-relative accesses land in the fixed high page
  p_page_base_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_o && (fetch_use == FU_PAGE) |-> mem_addr_o[ADDR_W-1:DATA_W] == IO_PAGE);

  // R6: a request right after an acknowledged read is the write-back to the same byte
  p_rmw_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_o && $past(mem_req_o && !mem_we_o && mem_ready_i)
      |-> mem_we_o && (mem_addr_o == $past(mem_addr_o)));

  // R2: HL is only written back as the data access completes
  p_hl_at_access_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hl_we_o |-> mem_req_o && mem_ready_i && done_o);

  // R1: write-back only accompanies an acknowledged read
  p_wb_on_read_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_we_o |-> mem_req_o && !mem_we_o && mem_ready_i);

endmodule

// File: tb/lsag_unit_tb.sv
`timescale 1ns/1ps
module lsag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] bc = '0, de = '0, hl = '0;
  logic [7:0]  acc = '0, fetch_data = '0, rdata = '0;
  logic        ready = 1'b1;

  logic        busy, done, fetch_req, mem_req, mem_we, hl_we, wb_we;
  logic [15:0] mem_addr, hl_data;
  logic [7:0]  mem_wdata, wb_data;

  always #2.5 clk = ~clk;

  lsag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .bc_i(bc), .de_i(de), .hl_i(hl), .acc_i(acc),
    .fetch_data_i(fetch_data), .mem_rdata_i(rdata), .mem_ready_i(ready),
    .busy_o(busy), .done_o(done), .fetch_req_o(fetch_req), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .hl_we_o(hl_we), .hl_data_o(hl_data), .wb_we_o(wb_we), .wb_data_o(wb_data)
  );

  // expected step: kind 0 fetch, 1 read, 2 write
  typedef struct {
    int          kind;
    logic [15:0] addr;
    logic [7:0]  data;
    bit          fin;
    bit          wb;
  } step_t;

  step_t       q[$];
  logic [7:0]  mem_m [int];
  bit          m_hl_en;
  logic [15:0] m_hl;
  string       cur_tag = "R10";
  int          n_chk = 0, n_bad = 0;
  bit          rnd_ready = 1'b0;
  bit          finished = 1'b0;

  function automatic logic [7:0] mem_rd(logic [15:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic step_t mk(int k, logic [15:0] a, logic [7:0] d);
    step_t s;
    s.kind = k; s.addr = a; s.data = d; s.fin = 1'b0; s.wb = 1'b0;
    return s;
  endfunction

  function automatic void chk(string tg, string nm, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tg, nm, act, exp, $time);
    end
  endfunction

  // builds the expected step list from the requirements
  task automatic build();
    logic [7:0]  b0, b1, v;
    logic [15:0] a;
    step_t       s;
    m_hl_en = 1'b0;
    m_hl    = hl;
    a       = hl;
    if (op < 5'd16) begin
      case (op[2:0])
        3'd0: begin a = bc; cur_tag = "R1"; end
        3'd1: begin a = de; cur_tag = "R1"; end
        3'd2: begin a = hl; cur_tag = "R1"; end
        3'd3: begin a = hl; m_hl_en = 1'b1; m_hl = hl + 16'd1; cur_tag = "R2"; end
        3'd4: begin a = hl; m_hl_en = 1'b1; m_hl = hl - 16'd1; cur_tag = "R2"; end
        3'd5: begin a = {8'hFF, bc[7:0]}; cur_tag = "R3"; end
        3'd6: begin
          b0 = 8'($urandom); q.push_back(mk(0, 16'h0, b0));
          a = {8'hFF, b0}; cur_tag = "R3";
        end
        default: begin
          b0 = 8'($urandom); b1 = 8'($urandom);
          q.push_back(mk(0, 16'h0, b0)); q.push_back(mk(0, 16'h0, b1));
          a = {b1, b0}; cur_tag = "R4";
        end
      endcase
      if (op[3]) q.push_back(mk(2, a, acc));
      else begin s = mk(1, a, 8'h0); s.wb = 1'b1; q.push_back(s); end
    end else if (op == 5'd16) begin
      b0 = 8'($urandom);
      q.push_back(mk(0, 16'h0, b0));
      q.push_back(mk(2, hl, b0));
      cur_tag = "R5";
    end else begin
      v = mem_rd(hl);
      q.push_back(mk(1, hl, 8'h0));
      q.push_back(mk(2, hl, (op == 5'd17) ? v + 8'd1 : v - 8'd1));
      cur_tag = "R6";
    end
    q[q.size()-1].fin = 1'b1;
  endtask

  // model advance on the clock
  always @(posedge clk) begin
    bit was_empty;
    if (!rst_n) q.delete();
    else begin
      was_empty = (q.size() == 0);
      if (!was_empty && ready) begin
        if (q[0].kind == 2) mem_m[int'(q[0].addr)] = q[0].data;
        void'(q.pop_front());
      end
      if (was_empty && start && op <= 5'd18) build();
    end
  end

  // drive acknowledge and returned bytes, then compare away from the edge
  always @(negedge clk) begin
    string tg;
    step_t s;
    ready      = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
    fetch_data = 8'($urandom);
    rdata      = 8'($urandom);
    if (q.size() != 0) begin
      if (q[0].kind == 0) fetch_data = q[0].data;
      if (q[0].kind == 1) rdata = mem_rd(q[0].addr);
    end
    #1;
    if (q.size() == 0) begin
      tg = (rst_n && start && op > 5'd18) ? "R12" : "R10";
      chk(tg, "busy", 16'(busy), 16'd0);
      chk(tg, "fetch_req", 16'(fetch_req), 16'd0);
      chk(tg, "mem_req", 16'(mem_req), 16'd0);
      chk(tg, "done", 16'(done), 16'd0);
      chk(tg, "hl_we", 16'(hl_we), 16'd0);
      chk(tg, "wb_we", 16'(wb_we), 16'd0);
    end else begin
      s  = q[0];
      tg = ready ? cur_tag : "R8";
      chk("R9", "busy", 16'(busy), 16'd1);
      chk("R7", "fetch_req", 16'(fetch_req), 16'(s.kind == 0));
      chk("R7", "mem_req", 16'(mem_req), 16'(s.kind != 0));
      if (s.kind != 0) begin
        chk(tg, "mem_we", 16'(mem_we), 16'(s.kind == 2));
        chk(tg, "mem_addr", mem_addr, s.addr);
        if (s.kind == 2) chk(tg, "mem_wdata", 16'(mem_wdata), 16'(s.data));
      end
      chk("R11", "done", 16'(done), 16'(ready && s.fin));
      chk("R2", "hl_we", 16'(hl_we), 16'(ready && s.fin && m_hl_en));
      if (ready && s.fin && m_hl_en) chk("R2", "hl_data", hl_data, m_hl);
      chk("R1", "wb_we", 16'(wb_we), 16'(ready && s.kind == 1 && s.wb));
      if (ready && s.kind == 1 && s.wb) chk("R1", "wb_data", 16'(wb_data), 16'(rdata));
    end
  end

  // one operation; with scramble set, inputs churn while busy (R9, R11)
  task automatic run_op(logic [4:0] o, logic [15:0] b, logic [15:0] d,
                        logic [15:0] h, logic [7:0] a, bit scramble);
    @(negedge clk);
    op = o; bc = b; de = d; hl = h; acc = a; start = 1'b1;
    @(negedge clk);
    while (q.size() != 0) begin
      if (scramble) begin
        start = 1'($urandom); op = 5'($urandom);
        bc = 16'($urandom); de = 16'($urandom); hl = 16'($urandom); acc = 8'($urandom);
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);   // R10: idle outputs checked during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // every op code once, with start held through the operation
    for (int o = 0; o < 19; o++)
      run_op(5'(o), 16'h1234, 16'h5678, 16'h9ABC, 8'hA5, 1'b0);
    // R2 wrap at both ends of HL
    run_op(5'd3, 16'h0001, 16'h0002, 16'hFFFF, 8'h11, 1'b0);
    run_op(5'd12, 16'h0001, 16'h0002, 16'h0000, 8'h22, 1'b0);
    run_op(5'd11, 16'h0001, 16'h0002, 16'hFFFF, 8'h33, 1'b0);
    // R6 byte wrap
    mem_m[int'(16'h4000)] = 8'hFF;
    run_op(5'd17, 16'h0, 16'h0, 16'h4000, 8'h0, 1'b0);
    mem_m[int'(16'h4001)] = 8'h00;
    run_op(5'd18, 16'h0, 16'h0, 16'h4001, 8'h0, 1'b0);
    // R12 rejected codes
    run_op(5'd19, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
    run_op(5'd31, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
    // R8 stalls, R9/R11 input churn
    rnd_ready = 1'b1;
    for (int i = 0; i < 400; i++)
      run_op(5'($urandom % 20), 16'($urandom), 16'($urandom), 16'($urandom),
             8'($urandom), 1'b1);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule